// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This block is a small multicycle processor whose whole instruction set is one operation: subtract one memory word from another, store the difference, and branch when the difference is not positive. An instruction has no opcode. It is three consecutive memory words `a`, `b`, `c`, each a direct word address. The core computes `mem[b] := mem[b] - mem[a]` in two's complement. If the stored difference passes the branch test, the program counter is loaded with `c`. Otherwise it advances by three words.

The core reaches a single-port synchronous word memory with one-cycle read latency, and it performs at most one access per cycle. An operand address with its most significant bit set (a negative address) does not go to memory. It reaches a small I/O port instead, and the instruction then becomes a plain copy. A negative `a` takes a word from the input handshake and stores it at `b`. A negative `b` sends `mem[a]` out with a one-cycle strobe. A negative `a` together with a negative `b` passes the input word straight to the output.

The `strict_i` input selects a variant branch test that branches only on a strictly negative result. A taken branch to a negative target stops the core for good, until the next reset.

Top module: `sbranch_core`

## Requirements
- R1: While reset is held and on the first cycle after it, `halted_o`, `out_valid_o` and `in_ready_o` are low. The first access is a read (`mem_we_o`=0) of address 0, because the program counter resets to 0.
- R2: The core fetches an instruction as three reads at pc, pc+1 and pc+2, in that order. It makes at most one memory access per cycle, and `mem_we_o` is high only together with `mem_req_o`.
- R3: For a memory-to-memory instruction, the core writes `mem[b] - mem[a]` back to address `b`, wrapped to DW bits (0x8000 - 1 = 0x7FFF and 0x7FFF - 0xFFFF = 0x8000 at DW=16). Every write goes to the address read on the cycle before.
- R4: With `strict_i`=0, a result that is zero or negative (MSB set) makes the next program counter `c`. A positive result gives pc+3.
- R5: With `strict_i`=1, only a negative result branches. A zero result falls through to pc+3.
- R6: When `a` is negative, the core raises `in_ready_o` and waits with no memory access until `in_valid_i` is high. The word is taken on the cycle where both signals are high and is written to `mem[b]`.
- R7: When `b` is negative and `a` is not, the core drives `mem[a]` on `out_data_o` for a single cycle with `out_valid_o` high. It writes nothing to memory.
- R8: When both `a` and `b` are negative, the accepted input word appears on `out_data_o` with `out_valid_o`, and memory is not written.
- R9: A taken branch whose target `c` is negative sets `halted_o`. The signal stays high until reset, and while it is high the core issues no memory request and no output strobe.
- R10: An I/O instruction (negative `a` or negative `b`) never branches and never halts, even when `c` is negative. It always continues at pc+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| strict_i | input | 1 | 1: branch only on a negative result; 0: branch on zero or negative |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | DW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |
| in_data_i | input | DW | Input port word |
| in_valid_i | input | 1 | Input word available |
| in_ready_o | output | 1 | Core waits for an input word |
| out_data_o | output | DW | Output port word |
| out_valid_o | output | 1 | Output word strobe, one cycle |
| halted_o | output | 1 | Core has stopped |

## Verification
The checker watches several port rules on every cycle. A write must come with a request and must go to the address read on the cycle before. While the core stalls for input, no memory access may occur and the stall must persist. The output strobe must last one cycle, and the halted state must be sticky and silent. These rules cannot show whether the subtraction wraps correctly, whether a branch follows the right test for the selected mode, or whether an I/O instruction falls through. Those show only in the bench's programs. The bench compares the output words a program emits along its branch path against a queue of expected values, and it then inspects the memory the program has written.

// File: rtl/sbranch_pkg.sv
package sbranch_pkg;

  localparam int unsigned INSTR_WORDS = 3;

  typedef enum logic [2:0] {
    ST_FA   = 3'd0,  // read word a
    ST_FB   = 3'd1,  // read word b, capture a
    ST_FC   = 3'd2,  // read word c, capture b
    ST_DEC  = 3'd3,  // capture c, read mem[a] or go to input wait
    ST_RB   = 3'd4,  // capture mem[a], read mem[b] or emit output
    ST_WB   = 3'd5,  // write difference, resolve branch
    ST_IN   = 3'd6,  // wait for input handshake
    ST_HALT = 3'd7
  } sb_state_e;

endpackage

// File: rtl/sbranch_rst_sync.sv
module sbranch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/sbranch_alu.sv
module sbranch_alu #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] minuend_i,
  input  logic [DW-1:0] subtrahend_i,
  input  logic          strict_i,
  output logic [DW-1:0] diff_o,
  output logic          take_o
);

  logic is_neg;
  logic is_zero;

  always_comb begin
    diff_o  = minuend_i - subtrahend_i;
    is_neg  = diff_o[DW-1];
    is_zero = (diff_o == '0);
    take_o  = is_neg | (~strict_i & is_zero);
  end

endmodule

// File: rtl/sbranch_core.sv
module sbranch_core
  import sbranch_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strict_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  output logic          halted_o
);

  localparam logic [DW-1:0] STEP   = DW'(INSTR_WORDS);
  localparam logic [DW-1:0] OFS_B  = DW'(1);
  localparam logic [DW-1:0] OFS_C  = DW'(2);

  logic          rst_int_n;
  sb_state_e     state_q, state_n;
  logic [DW-1:0] pc_q, pc_n;
  logic          pc_en;
  logic [DW-1:0] opa_q, opb_q, opc_q, va_q;
  logic          lat_a, lat_b, lat_c, lat_v;
  logic [DW-1:0] diff;
  logic          take;
  logic          a_io, b_io, c_io;
  logic [DW-1:0] pc_seq;

  sbranch_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sbranch_alu #(.DW(DW)) u_alu (
    .minuend_i    (mem_rdata_i),
    .subtrahend_i (va_q),
    .strict_i     (strict_i),
    .diff_o       (diff),
    .take_o       (take)
  );

  assign a_io   = opa_q[DW-1];
  assign b_io   = opb_q[DW-1];
  assign c_io   = opc_q[DW-1];
  assign pc_seq = pc_q + STEP;

  // next-state and output decode
  always_comb begin
    state_n     = state_q;
    pc_n        = pc_q;
    pc_en       = 1'b0;
    lat_a       = 1'b0;
    lat_b       = 1'b0;
    lat_c       = 1'b0;
    lat_v       = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = '0;
    case (state_q)
      ST_FA: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pc_q;
        state_n    = ST_FB;
      end
      ST_FB: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pc_q + OFS_B;
        lat_a      = 1'b1;
        state_n    = ST_FC;
      end
      ST_FC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pc_q + OFS_C;
        lat_b      = 1'b1;
        state_n    = ST_DEC;
      end
      ST_DEC: begin
        lat_c = 1'b1;
        if (a_io) begin
          state_n = ST_IN;
        end else begin
          mem_req_o  = 1'b1;
          mem_addr_o = opa_q;
          state_n    = ST_RB;
        end
      end
      ST_RB: begin
        lat_v = 1'b1;
        if (b_io) begin
          out_valid_o = 1'b1;
          out_data_o  = mem_rdata_i;
          pc_en       = 1'b1;
          pc_n        = pc_seq;
          state_n     = ST_FA;
        end else begin
          mem_req_o  = 1'b1;
          mem_addr_o = opb_q;
          state_n    = ST_WB;
        end
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = opb_q;
        mem_wdata_o = diff;
        if (take && c_io) begin
          state_n = ST_HALT;
        end else begin
          pc_en   = 1'b1;
          pc_n    = take ? opc_q : pc_seq;
          state_n = ST_FA;
        end
      end
      ST_IN: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          if (b_io) begin
            out_valid_o = 1'b1;
            out_data_o  = in_data_i;
          end else begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = opb_q;
            mem_wdata_o = in_data_i;
          end
          pc_en   = 1'b1;
          pc_n    = pc_seq;
          state_n = ST_FA;
        end
      end
      default: begin
        state_n = ST_HALT;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_FA;
      pc_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      opc_q   <= '0;
      va_q    <= '0;
    end else begin
      state_q <= state_n;
      if (pc_en) pc_q  <= pc_n;
      if (lat_a) opa_q <= mem_rdata_i;
      if (lat_b) opb_q <= mem_rdata_i;
      if (lat_c) opc_q <= mem_rdata_i;
      if (lat_v) va_q  <= mem_rdata_i;
    end
  end

  assign halted_o = (state_q == ST_HALT);

endmodule

module sbranch_core_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          halted_o
);

  a_r2_write_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

  a_r3_write_to_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !in_ready_o) |->
      ($past(mem_req_o) && !$past(mem_we_o) && mem_addr_o == $past(mem_addr_o)));

  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i) |-> !mem_req_o);

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i) |=> in_ready_o);

  a_r7_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);

  a_r9_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (!mem_req_o && !out_valid_o && !in_ready_o));

endmodule

bind sbranch_core sbranch_core_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .halted_o    (halted_o)
);

// File: tb/sbranch_core_tb.sv
`timescale 1ns/1ps
module sbranch_core_tb;

  logic        clk;
  logic        rst_n;
  logic        strict_i;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [15:0] in_data_i;
  logic        in_valid_i, in_ready_o;
  logic [15:0] out_data_o;
  logic        out_valid_o, halted_o;

  logic [15:0] mem [0:255];
  logic [15:0] exp_q [$];
  logic [15:0] in_q  [$];
  int          n_checks, n_fail, cycles;

  sbranch_core #(.DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .strict_i(strict_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .halted_o(halted_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[7:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'(cycles), 16'd0);
      finish_run();
    end
  end

  // scoreboard monitor for the output port
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected output", out_data_o, 16'hxxxx);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_data_o == e, "R4/R5/R7/R8 output word", out_data_o, e);
      end
    end
  end

  task automatic put_ins(input int at, input int a, input int b, input int c);
    mem[at]   = 16'(a);
    mem[at+1] = 16'(b);
    mem[at+2] = 16'(c);
  endtask

  task automatic push_out(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid_i = 1'b0;
    in_data_i = '0;
    repeat (4) @(negedge clk);
    // R1: state held in reset
    chk(!halted_o && !out_valid_o && !in_ready_o, "R1 outputs in reset",
        {13'd0, halted_o, out_valid_o, in_ready_o}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_o && !mem_we_o && mem_addr_o == 16'h0 && !halted_o, "R1 first access",
        mem_addr_o, 16'h0);
  endtask

  // input driver: waits for ready, lets the core stall, then hands a word over
  task automatic feed_inputs();
    while (in_q.size() > 0) begin
      @(negedge clk);
      while (!in_ready_o && !halted_o) @(negedge clk);
      if (halted_o) return;
      repeat (3) begin
        chk(in_ready_o && !mem_req_o, "R6 stall without access",
            {14'd0, in_ready_o, mem_req_o}, 16'h2);
        @(negedge clk);
      end
      in_data_i  = in_q.pop_front();
      in_valid_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0;
    end
  endtask

  task automatic wait_halt();
    int n;
    n = 0;
    while (!halted_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(halted_o, "R9 halt reached", {15'd0, halted_o}, 16'h1);
  endtask

  task automatic check_silent();
    int act;
    act = 0;
    repeat (20) begin
      @(negedge clk);
      if (mem_req_o || out_valid_o || !halted_o) act++;
    end
    chk(act == 0, "R9 silent and sticky after halt", 16'(act), 16'h0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cycles = 0;
    rst_n = 1'b0; strict_i = 1'b0; in_valid_i = 1'b0; in_data_i = '0;

    // ---------- program 1: default branch test ----------
    clear_mem();
    put_ins(0,  100, 101, 6);    // 5-5=0 -> branch (R4)
    put_ins(3,  102, -1, 0);     // skipped
    put_ins(6,  103, -1, 9);     // output 0x0011 (R7)
    put_ins(9,  104, 105, 15);   // 3-1=2 -> fall through (R4)
    put_ins(12, 106, -1, 15);    // output 0x0022
    put_ins(15, -1, 107, 18);    // input -> mem[107] (R6)
    put_ins(18, 107, -1, 21);    // output mem[107]
    put_ins(21, -1, -1, -1);     // input -> output, no halt (R8, R10)
    put_ins(24, 108, 109, 27);   // 0x8000-1 -> 0x7FFF positive (R3)
    put_ins(27, 110, -1, 30);    // output 0x0033
    put_ins(30, 111, 111, -1);   // 0 -> branch to negative: halt (R9)
    mem[100] = 16'd5;  mem[101] = 16'd5;  mem[102] = 16'h0BAD;
    mem[103] = 16'h0011; mem[104] = 16'd1; mem[105] = 16'd3;
    mem[106] = 16'h0022; mem[108] = 16'd1; mem[109] = 16'h8000;
    mem[110] = 16'h0033; mem[111] = 16'h0077;
    push_out(16'h0011); push_out(16'h0022); push_out(16'h1234);
    push_out(16'h0055); push_out(16'h0033);
    in_q.push_back(16'h1234); in_q.push_back(16'h0055);
    do_reset();
    fork
      feed_inputs();
      wait_halt();
    join
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 branch path outputs", 16'(exp_q.size()), 16'h0);
    chk(mem[101] == 16'h0000, "R3 difference stored", mem[101], 16'h0000);
    chk(mem[105] == 16'h0002, "R4 positive result stored", mem[105], 16'h0002);
    chk(mem[107] == 16'h1234, "R6 input written to b", mem[107], 16'h1234);
    chk(mem[109] == 16'h7FFF, "R3 wrap below", mem[109], 16'h7FFF);
    chk(mem[111] == 16'h0000, "R9 self subtract", mem[111], 16'h0000);
    chk(mem[103] == 16'h0011, "R7 no write on output", mem[103], 16'h0011);
    check_silent();

    // ---------- program 2: strict branch test ----------
    clear_mem();
    exp_q.delete(); in_q.delete();
    strict_i = 1'b1;
    put_ins(0,  100, 101, 6);    // 0 -> falls through in strict mode (R5)
    put_ins(3,  102, -1, 6);     // output 0x0044
    put_ins(6,  103, 104, 12);   // 1-2=-1 -> branch (R5)
    put_ins(9,  105, -1, 12);    // skipped
    put_ins(12, 106, -1, 15);    // output 0x0066
    put_ins(15, 107, 107, -1);   // 0, strict -> no halt (R5)
    put_ins(18, 108, 109, -1);   // 0x7FFF-0xFFFF=0x8000 negative -> halt (R3, R9)
    mem[100] = 16'd7;  mem[101] = 16'd7;  mem[102] = 16'h0044;
    mem[103] = 16'd2;  mem[104] = 16'd1;  mem[105] = 16'h0BAD;
    mem[106] = 16'h0066; mem[107] = 16'h0009;
    mem[108] = 16'hFFFF; mem[109] = 16'h7FFF;
    push_out(16'h0044); push_out(16'h0066);
    do_reset();
    wait_halt();
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 strict path outputs", 16'(exp_q.size()), 16'h0);
    chk(mem[101] == 16'h0000, "R5 zero stored", mem[101], 16'h0000);
    chk(mem[104] == 16'hFFFF, "R3 negative stored", mem[104], 16'hFFFF);
    chk(mem[107] == 16'h0000, "R5 zero no halt", mem[107], 16'h0000);
    chk(mem[109] == 16'h8000, "R3 wrap above", mem[109], 16'h8000);
    check_silent();

    finish_run();
  end

endmodule